// File: doc/BRIEF.md
# Nibble-Addressed Register Command Decoder

This block sits behind a byte-oriented serial receiver and turns each received command byte into an action on a small interface register set. Every byte carries two 4-bit fields: the low nibble selects a field of the set, the high nibble is the data for it. Because only four data bits travel per byte, a 16-bit value is built up in a holding register one nibble at a time. A separate byte then names the destination register, and that byte is what releases the value.

When the target-address field is written, the block emits a single-cycle register write. The write carries the destination address and the full 16-bit holding value. When the special-command field is written, the block emits a single-cycle command strobe with the 4-bit code, which starts an internal sequence elsewhere in the chip. All other field codes are dropped. The holding register keeps its contents, so the same value can be written to several registers, or changed one nibble at a time between commits.

Top module: `nibble_cmd_decoder`

## Requirements
- R1: While and after reset, `regWrEn` and `cmdStrobe` are low and the holding register is zero, so an immediate commit writes 0x0000.
- R2: Command byte bits [3:0] are the field code and bits [7:4] the data nibble; bit 0 of the code is the first serial bit after the start bit and data bit 0 is the fifth.
- R3: Field codes 0, 1, 2 and 3 load the data nibble into holding bits [3:0], [7:4], [11:8] and [15:12] respectively, leaving the other twelve bits unchanged.
- R4: Field code 4 raises `regWrEn` for exactly one cycle, in the cycle after the byte is accepted, with `regWrAddr` equal to the data nibble and `regWrData` equal to the holding value before that byte.
- R5: A commit does not alter the holding register; a second commit without nibble writes in between carries the same data.
- R6: Field code 5 raises `cmdStrobe` for exactly one cycle, in the cycle after the byte is accepted, with `cmdCode` equal to the data nibble.
- R7: Field codes 6 to 15 produce no strobe and leave the holding register unchanged.
- R8: A byte presented while `cmdValid` is low has no effect on strobes or on the holding register.
- R9: Bytes accepted on consecutive cycles are each acted on, in order, and `regWrEn` and `cmdStrobe` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmdByte | input | 8 | Received command byte: [3:0] field code, [7:4] data nibble |
| cmdValid | input | 1 | High for one cycle per accepted byte |
| regWrEn | output | 1 | One-cycle write strobe to the calibration register file |
| regWrAddr | output | 4 | Destination register address for the write |
| regWrData | output | 16 | Assembled 16-bit value for the write |
| cmdStrobe | output | 1 | One-cycle special-command strobe |
| cmdCode | output | 4 | Special-command code |

## Verification
A wrong holding-register nibble stays hidden until the next commit. It then shows in `regWrData` one cycle after the commit byte. For this reason every nibble-load, ignore and no-valid scenario ends with a commit. A decode error that fires the wrong strobe shows one cycle after the offending byte, as a pulse on `regWrEn` or `cmdStrobe` where none is expected, or as a missing pulse. A strobe that sticks high shows one cycle later, when the pulse fails to drop.

// File: rtl/nibcmd_pkg.sv
package nibcmd_pkg;
  localparam int NIB_W    = 4;
  localparam int DATA_W   = 16;
  localparam int NUM_NIBS = DATA_W / NIB_W;
  localparam int BYTE_W   = 2 * NIB_W;

  // field codes; the low NUM_NIBS codes select holding-register nibbles
  localparam logic [NIB_W-1:0] CODE_COMMIT  = NIB_W'(NUM_NIBS);
  localparam logic [NIB_W-1:0] CODE_SPECIAL = NIB_W'(NUM_NIBS + 1);

  typedef struct packed {
    logic [NUM_NIBS-1:0] holdWe;
    logic                commit;
    logic                special;
    logic [NIB_W-1:0]    nibble;
  } ctrl_t;
endpackage

// File: rtl/nibcmd_ctrl.sv
module nibcmd_ctrl
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdValid,
  output ctrl_t             ctrl
);
  logic [NIB_W-1:0] fieldCode;

  assign fieldCode = cmdByte[NIB_W-1:0];

  always_comb begin
    ctrl        = '0;
    ctrl.nibble = cmdByte[BYTE_W-1:NIB_W];
    for (int k = 0; k < NUM_NIBS; k++) begin
      ctrl.holdWe[k] = cmdValid && (fieldCode == NIB_W'(k));
    end
    ctrl.commit  = cmdValid && (fieldCode == CODE_COMMIT);
    ctrl.special = cmdValid && (fieldCode == CODE_SPECIAL);
  end

  AST_CTRL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |-> (ctrl.holdWe == '0 && !ctrl.commit && !ctrl.special)) else $error("ctrl active without valid"); // R8
endmodule

// File: rtl/nibcmd_datapath.sv
module nibcmd_datapath
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  output logic              wrEn,
  output logic [NIB_W-1:0]  wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic              cmdStb,
  output logic [NIB_W-1:0]  cmdCode
);
  logic [DATA_W-1:0] holdReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdReg <= '0;
    end else begin
      for (int k = 0; k < NUM_NIBS; k++) begin
        if (ctrl.holdWe[k]) holdReg[k*NIB_W +: NIB_W] <= ctrl.nibble;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrEn   <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrEn <= ctrl.commit;
      if (ctrl.commit) begin
        wrAddr <= ctrl.nibble;
        wrData <= holdReg;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdStb  <= 1'b0;
      cmdCode <= '0;
    end else begin
      cmdStb <= ctrl.special;
      if (ctrl.special) cmdCode <= ctrl.nibble;
    end
  end

  for (genvar g = 0; g < NUM_NIBS; g++) begin : g_nibChk
    AST_NIBBLE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.holdWe[g] |=> $stable(holdReg[g*NIB_W +: NIB_W])) else $error("nibble %0d changed", g); // R3
  end

  AST_COMMIT_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.commit |=> (wrEn && wrData == $past(holdReg))) else $error("commit data mismatch"); // R4
endmodule

// File: rtl/nibble_cmd_decoder.sv
module nibble_cmd_decoder
  import nibcmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] cmdByte,
  input  logic              cmdValid,
  output logic              regWrEn,
  output logic [NIB_W-1:0]  regWrAddr,
  output logic [DATA_W-1:0] regWrData,
  output logic              cmdStrobe,
  output logic [NIB_W-1:0]  cmdCode
);
  ctrl_t ctrl;

  nibcmd_ctrl i_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdByte  (cmdByte),
    .cmdValid (cmdValid),
    .ctrl     (ctrl)
  );

  nibcmd_datapath i_datapath (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl    (ctrl),
    .wrEn    (regWrEn),
    .wrAddr  (regWrAddr),
    .wrData  (regWrData),
    .cmdStb  (cmdStrobe),
    .cmdCode (cmdCode)
  );

  AST_COMMIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte[NIB_W-1:0] == CODE_COMMIT) |=>
      (regWrEn && regWrAddr == $past(cmdByte[BYTE_W-1:NIB_W]))) else $error("commit pulse"); // R4
  AST_SPECIAL_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte[NIB_W-1:0] == CODE_SPECIAL) |=>
      (cmdStrobe && cmdCode == $past(cmdByte[BYTE_W-1:NIB_W]))) else $error("special pulse"); // R6
  AST_UNUSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdByte[NIB_W-1:0] > CODE_SPECIAL) |=> (!regWrEn && !cmdStrobe)) else $error("unused code acted"); // R7
  AST_NO_VALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> (!regWrEn && !cmdStrobe)) else $error("strobe without valid"); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(regWrEn && cmdStrobe)) else $error("both strobes"); // R9
endmodule

// File: tb/test_nibble_cmd_decoder.sv
module test_nibble_cmd_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cmdByte = '0;
  logic        cmdValid = 1'b0;
  logic        regWrEn;
  logic [3:0]  regWrAddr;
  logic [15:0] regWrData;
  logic        cmdStrobe;
  logic [3:0]  cmdCode;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  nibble_cmd_decoder i_nibble_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cmdByte(cmdByte), .cmdValid(cmdValid),
    .regWrEn(regWrEn), .regWrAddr(regWrAddr), .regWrData(regWrData),
    .cmdStrobe(cmdStrobe), .cmdCode(cmdCode)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // present one byte for one cycle; returns at the following negedge,
  // when the registered outputs for that byte are visible
  task automatic sendByte(input logic [3:0] code, input logic [3:0] nib);
    @(negedge clk);
    cmdByte  = {nib, code};
    cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    cmdByte  = '0;
  endtask

  task automatic commitExpect(input string req, input logic [3:0] dst, input logic [15:0] expData);
    sendByte(4'd4, dst);
    check({req, " wrEn"}, regWrEn, 1'b1);
    check({req, " wrAddr"}, regWrAddr, dst);
    check({req, " wrData"}, regWrData, expData);
    check({req, " no cmdStrobe"}, cmdStrobe, 1'b0);
  endtask

  task automatic testReset();
    check("R1 wrEn", regWrEn, 1'b0);
    check("R1 cmdStrobe", cmdStrobe, 1'b0);
    commitExpect("R1 zero hold", 4'h3, 16'h0000);
  endtask

  task automatic testNibbleLoad();
    sendByte(4'd0, 4'hD);
    sendByte(4'd1, 4'hA);
    sendByte(4'd2, 4'hE);
    sendByte(4'd3, 4'hB);
    commitExpect("R3 full load", 4'hA, 16'hBEAD);
    @(negedge clk);
    check("R4 pulse width", regWrEn, 1'b0);
    // R2: byte 0x71 = code 1, nibble 7
    @(negedge clk);
    cmdByte = 8'h71; cmdValid = 1'b1;
    @(negedge clk);
    cmdValid = 1'b0;
    commitExpect("R2 field order", 4'h0, 16'hBE7D);
  endtask

  task automatic testRepeatCommit();
    commitExpect("R5 first", 4'h1, 16'hBE7D);
    commitExpect("R5 second", 4'hF, 16'hBE7D);
  endtask

  task automatic testPartial();
    sendByte(4'd2, 4'h0);
    commitExpect("R3 partial", 4'h2, 16'hB07D);
  endtask

  task automatic testSpecial();
    sendByte(4'd5, 4'h9);
    check("R6 strobe", cmdStrobe, 1'b1);
    check("R6 code", cmdCode, 4'h9);
    check("R6 no write", regWrEn, 1'b0);
    @(negedge clk);
    check("R6 pulse width", cmdStrobe, 1'b0);
    commitExpect("R6 hold kept", 4'h4, 16'hB07D);
  endtask

  task automatic testIgnored();
    for (int c = 6; c < 16; c++) begin
      sendByte(4'(c), 4'(c ^ 5));
      check("R7 no write", regWrEn, 1'b0);
      check("R7 no cmd", cmdStrobe, 1'b0);
    end
    commitExpect("R7 hold kept", 4'h6, 16'hB07D);
  endtask

  task automatic testNoValid();
    @(negedge clk);
    cmdByte = 8'h54; cmdValid = 1'b0;
    @(negedge clk);
    check("R8 no write", regWrEn, 1'b0);
    cmdByte = 8'h35;
    @(negedge clk);
    check("R8 no cmd", cmdStrobe, 1'b0);
    cmdByte = 8'hF0;
    @(negedge clk);
    cmdByte = '0;
    commitExpect("R8 hold kept", 4'h7, 16'hB07D);
  endtask

  task automatic testBackToBack();
    @(negedge clk);
    cmdValid = 1'b1;
    cmdByte = 8'h10;            // nibble0 = 1
    @(negedge clk);
    cmdByte = 8'hC4;            // commit to 0xC
    @(negedge clk);
    cmdByte = 8'h65;            // special 6
    check("R9 commit", regWrEn, 1'b1);
    check("R9 commit data", regWrData, 16'hB071);
    check("R9 commit addr", regWrAddr, 4'hC);
    @(negedge clk);
    cmdByte = 8'h24;            // commit to 0x2
    check("R9 special", cmdStrobe, 1'b1);
    check("R9 exclusive", regWrEn, 1'b0);
    check("R9 special code", cmdCode, 4'h6);
    @(negedge clk);
    cmdValid = 1'b0;
    cmdByte = '0;
    check("R9 second commit", regWrEn, 1'b1);
    check("R9 second data", regWrData, 16'hB071);
    check("R9 special dropped", cmdStrobe, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testNibbleLoad();
    testRepeatCommit();
    testPartial();
    testSpecial();
    testIgnored();
    testNoValid();
    testBackToBack();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule